// File: doc/BRIEF.md
# Two-Stage Frequency Search Controller

This block steers the tuning code of a digitally tuned ring oscillator until the oscillator runs at a target frequency. It runs on a reference clock. The clock is split into fixed measurement windows of `WIN_CYCLES` reference cycles. An external counter reports how many oscillator cycles fell into each window. At the end of each window the controller compares that count with a target count and makes exactly one tuning decision.

The decision depends on the absolute error. A large error, above the search threshold, takes a coarse step. Coarse steps start at a quarter of the code range from the midpoint and halve on every coarse decision, as in a binary search. A moderate error, between the lock and search thresholds, takes a single-code fine step. A small error, at or below the lock threshold, holds the code and raises the locked flag.

Searching never stops, so the code keeps following temperature and supply drift after lock. If a large error comes back, the flag drops and the coarse search starts again with a quarter-range step. The tuning code is presented split into a delay-path select field and a delay-matrix field.

Top module: `fsc_search_ctrl`

## Requirements
- R1: After reset the tuning code is the range midpoint 128: coarse_sel = 3'b100, fine_sel = 5'b00000, and locked = 0.
- R2: One decision is made per window of 64 reference cycles. The inputs are sampled only on the last cycle of a window, and outputs change only on the cycle after that sample. Input values at any other cycle have no effect.
- R3: When osc_count is below target_count the code rises. When it is above target_count the code falls.
- R4: When |osc_count - target_count| > search_thresh the decision is coarse. The code moves by the current step, which starts at 64 and halves after each coarse decision, never going below 1.
- R5: When lock_thresh < |error| <= search_thresh the code moves by exactly 1.
- R6: When |error| <= lock_thresh the code is held and locked becomes 1.
- R7: Once set, locked stays 1 through fine decisions and is cleared only by a coarse decision.
- R8: The first coarse decision after any fine or lock decision uses a step of 64 again and then continues halving.
- R9: The code saturates at 0 and 255 and never wraps.
- R10: coarse_sel is code bits [7:5] and fine_sel is code bits [4:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| osc_count | input | 16 | Oscillator cycles counted in the current window |
| target_count | input | 16 | Wanted oscillator cycles per window |
| search_thresh | input | 16 | Error above which a coarse step is taken |
| lock_thresh | input | 16 | Error at or below which the loop is locked |
| coarse_sel | output | 3 | Delay-path select (upper code field) |
| fine_sel | output | 5 | Delay-matrix setting (lower code field) |
| locked | output | 1 | Frequency within the lock window |

## Verification
After rst_n is released, two reference edges pass in the reset synchronizer. The first window then closes on the 66th edge, when the inputs are captured, and the new code and flag appear after the 67th edge. Every later decision is due exactly 64 edges after the previous one. The bench keeps a count of the edges it has spent inside each window, so it always samples at the falling edge just after a due update. A mid-window check catches any early movement. The expected codes come from a step model of the requirements, driven with the bench's own oscillator model, count = 2*code + 20.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

  // Error classification for one measurement window
  typedef enum logic [1:0] {
    CLS_LOCK   = 2'd0,
    CLS_FINE   = 2'd1,
    CLS_COARSE = 2'd2
  } err_class_e;

  // Registered decision handed from the classifier to the step engine
  typedef struct packed {
    err_class_e cls;
    logic       raise;
  } decision_t;

endpackage

// File: rtl/fsc_reset_sync.sv
module fsc_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/fsc_window_timer.sv
module fsc_window_timer #(
  parameter int WIN_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic sample_en,
  output logic apply_en
);

  localparam int WCNT_W = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [WCNT_W-1:0] WCNT_LAST = WCNT_W'(WIN_CYCLES - 1);

  logic [WCNT_W-1:0] wcnt_q;
  logic [WCNT_W-1:0] wcnt_d;
  logic              apply_q;
  logic              apply_d;

  // Next state: the last cycle of a window is the sample slot,
  // the cycle after it is the apply slot.
  always_comb begin
    sample_en = (wcnt_q == WCNT_LAST);
    wcnt_d    = sample_en ? '0 : wcnt_q + 1'b1;
    apply_d   = sample_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q  <= '0;
      apply_q <= 1'b0;
    end else begin
      wcnt_q  <= wcnt_d;
      apply_q <= apply_d;
    end
  end

  assign apply_en = apply_q;

endmodule

// File: rtl/fsc_error_classifier.sv
module fsc_error_classifier
  import fsc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_en,
  input  logic [CNT_W-1:0] osc_count,
  input  logic [CNT_W-1:0] target_count,
  input  logic [CNT_W-1:0] search_thresh,
  input  logic [CNT_W-1:0] lock_thresh,
  output decision_t        decision
);

  logic             too_slow;
  logic [CNT_W-1:0] err_mag;
  decision_t        fresh;
  decision_t        dec_q;
  decision_t        dec_d;

  // Magnitude and direction, then dual-threshold classification
  always_comb begin
    too_slow = (osc_count < target_count);
    err_mag  = too_slow ? (target_count - osc_count) : (osc_count - target_count);
    fresh.raise = too_slow;
    if (err_mag > search_thresh) begin
      fresh.cls = CLS_COARSE;
    end else if (err_mag > lock_thresh) begin
      fresh.cls = CLS_FINE;
    end else begin
      fresh.cls = CLS_LOCK;
    end
    dec_d = sample_en ? fresh : dec_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q <= '{cls: CLS_LOCK, raise: 1'b0};
    end else begin
      dec_q <= dec_d;
    end
  end

  assign decision = dec_q;

endmodule

// File: rtl/fsc_step_engine.sv
module fsc_step_engine
  import fsc_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              apply_en,
  input  decision_t         decision,
  output logic [CODE_W-1:0] code,
  output logic              locked
);

  localparam int                STEP_W       = CODE_W - 1;
  localparam logic [CODE_W-1:0] CODE_MID     = CODE_W'(1) << (CODE_W - 1);
  localparam logic [CODE_W-1:0] CODE_MAX     = {CODE_W{1'b1}};
  localparam logic [STEP_W-1:0] STEP_QUARTER = STEP_W'(1) << (CODE_W - 2);
  localparam logic [STEP_W-1:0] STEP_ONE     = STEP_W'(1);

  logic [CODE_W-1:0] code_q,    code_d;
  logic [STEP_W-1:0] step_q,    step_d;
  logic              relearn_q, relearn_d;
  logic              locked_q,  locked_d;
  logic [STEP_W-1:0] eff_step;
  logic [STEP_W-1:0] move_amt;
  logic [CODE_W:0]   sum_wide;
  logic [CODE_W-1:0] moved;

  // Saturating move by move_amt in the decided direction
  always_comb begin
    eff_step = relearn_q ? STEP_QUARTER : step_q;
    move_amt = (decision.cls == CLS_COARSE) ? eff_step : STEP_ONE;
    sum_wide = {1'b0, code_q} + {{(CODE_W + 1 - STEP_W){1'b0}}, move_amt};
    if (decision.raise) begin
      moved = (sum_wide > {1'b0, CODE_MAX}) ? CODE_MAX : sum_wide[CODE_W-1:0];
    end else begin
      moved = (code_q < CODE_W'(move_amt)) ? '0 : code_q - CODE_W'(move_amt);
    end
  end

  // Next-state selection, enabled only in the apply slot
  always_comb begin
    code_d    = code_q;
    step_d    = step_q;
    relearn_d = relearn_q;
    locked_d  = locked_q;
    if (apply_en) begin
      unique case (decision.cls)
        CLS_COARSE: begin
          code_d    = moved;
          step_d    = (eff_step > STEP_ONE) ? (eff_step >> 1) : STEP_ONE;
          relearn_d = 1'b0;
          locked_d  = 1'b0;
        end
        CLS_FINE: begin
          code_d    = moved;
          relearn_d = 1'b1;
        end
        default: begin
          relearn_d = 1'b1;
          locked_d  = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q    <= CODE_MID;
      step_q    <= STEP_QUARTER;
      relearn_q <= 1'b0;
      locked_q  <= 1'b0;
    end else begin
      code_q    <= code_d;
      step_q    <= step_d;
      relearn_q <= relearn_d;
      locked_q  <= locked_d;
    end
  end

  assign code   = code_q;
  assign locked = locked_q;

endmodule

// File: rtl/fsc_search_ctrl.sv
module fsc_search_ctrl
  import fsc_pkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int COARSE_W   = 3,
  parameter int CNT_W      = 16,
  parameter int WIN_CYCLES = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [CNT_W-1:0]           osc_count,
  input  logic [CNT_W-1:0]           target_count,
  input  logic [CNT_W-1:0]           search_thresh,
  input  logic [CNT_W-1:0]           lock_thresh,
  output logic [COARSE_W-1:0]        coarse_sel,
  output logic [CODE_W-COARSE_W-1:0] fine_sel,
  output logic                       locked
);

  localparam int FINE_W = CODE_W - COARSE_W;

  logic              rst_sync_n;
  logic              sample_en;
  logic              apply_en;
  decision_t         decision;
  logic [CODE_W-1:0] code_q;

  fsc_reset_sync rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fsc_window_timer #(.WIN_CYCLES(WIN_CYCLES)) timer_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sample_en (sample_en),
    .apply_en  (apply_en)
  );

  fsc_error_classifier #(.CNT_W(CNT_W)) class_i (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .sample_en     (sample_en),
    .osc_count     (osc_count),
    .target_count  (target_count),
    .search_thresh (search_thresh),
    .lock_thresh   (lock_thresh),
    .decision      (decision)
  );

  fsc_step_engine #(.CODE_W(CODE_W)) step_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .apply_en (apply_en),
    .decision (decision),
    .code     (code_q),
    .locked   (locked)
  );

  // Upper field selects the delay path, lower field the delay-matrix tap
  assign coarse_sel = code_q[CODE_W-1 -: COARSE_W];
  assign fine_sel   = code_q[FINE_W-1:0];

endmodule

// File: rtl/fsc_search_ctrl_chk.sv
module fsc_search_ctrl_chk #(
  parameter int CODE_W     = 8,
  parameter int WIN_CYCLES = 64
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              sample_en,
  input logic              apply_en,
  input logic [CODE_W-1:0] code,
  input logic              locked
);

  localparam int GAP_W = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) + 1 : 2;
  localparam logic [GAP_W-1:0]  GAP_LAST = GAP_W'(WIN_CYCLES - 1);
  localparam logic [CODE_W-1:0] QUARTER  = CODE_W'(1) << (CODE_W - 2);

  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      gap_q <= '0;
    end else if (sample_en) begin
      gap_q <= '0;
    end else begin
      gap_q <= gap_q + 1'b1;
    end
  end

  // R2: samples fall exactly one window apart
  assert_window_len_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sample_en |-> (gap_q == GAP_LAST));

  // R2: the code only moves in the apply slot
  assert_code_moves_in_slot_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (code != $past(code)) |-> $past(apply_en));

  // R4: no step is larger than a quarter of the range
  assert_step_bound_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(apply_en) |-> (((code > $past(code)) ? (code - $past(code)) : ($past(code) - code)) <= QUARTER));

  // R6: entering lock leaves the code where it was
  assert_lock_holds_code_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(locked) |-> (code == $past(code)));

  // R7: while lock is kept, only single-code moves happen
  assert_locked_fine_only_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (locked && $past(locked)) |-> (((code > $past(code)) ? (code - $past(code)) : ($past(code) - code)) <= CODE_W'(1)));

  // R7: lock is lost only at a decision
  assert_unlock_in_slot_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(locked) |-> $past(apply_en));

endmodule

bind fsc_search_ctrl fsc_search_ctrl_chk #(
  .CODE_W     (CODE_W),
  .WIN_CYCLES (WIN_CYCLES)
) chk_i (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .sample_en  (sample_en),
  .apply_en   (apply_en),
  .code       (code_q),
  .locked     (locked)
);

// File: tb/fsc_search_ctrl_tb.sv
module fsc_search_ctrl_tb_top;

  logic        clk;
  logic        rst_n;
  logic [15:0] osc_count;
  logic [15:0] target_count;
  logic [15:0] search_thresh;
  logic [15:0] lock_thresh;
  logic [2:0]  coarse_sel;
  logic [4:0]  fine_sel;
  logic        locked;

  int checks;
  int failures;
  int spent;
  bit first_win;
  bit done;

  // reference model state
  int m_code;
  int m_step;
  bit m_relearn;
  bit m_locked;

  fsc_search_ctrl dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .osc_count     (osc_count),
    .target_count  (target_count),
    .search_thresh (search_thresh),
    .lock_thresh   (lock_thresh),
    .coarse_sel    (coarse_sel),
    .fine_sel      (fine_sel),
    .locked        (locked)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // behavioral oscillator: count per window = 2*code + 20
  always_comb osc_count = 16'(2 * int'({coarse_sel, fine_sel}) + 20);

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    spent += n;
    @(negedge clk);
  endtask

  task automatic next_decision();
    int want;
    want = first_win ? 67 : 64;
    repeat (want - spent) @(posedge clk);
    @(negedge clk);
    spent = 0;
    first_win = 0;
  endtask

  task automatic model_step();
    int cnt;
    int mag;
    int eff;
    bit up;
    cnt = 2 * m_code + 20;
    up  = cnt < int'(target_count);
    mag = up ? int'(target_count) - cnt : cnt - int'(target_count);
    if (mag > int'(search_thresh)) begin
      eff = m_relearn ? 64 : m_step;
      m_code = up ? m_code + eff : m_code - eff;
      m_step = (eff > 1) ? eff / 2 : 1;
      m_relearn = 0;
      m_locked = 0;
    end else if (mag > int'(lock_thresh)) begin
      m_code = up ? m_code + 1 : m_code - 1;
      m_relearn = 1;
    end else begin
      m_locked = 1;
      m_relearn = 1;
    end
    if (m_code > 255) m_code = 255;
    if (m_code < 0) m_code = 0;
  endtask

  task automatic compare_model(input string tag);
    check_eq({tag, " coarse_sel R10"}, int'(coarse_sel), m_code >> 5);
    check_eq({tag, " fine_sel R10"}, int'(fine_sel), m_code & 31);
    check_eq({tag, " locked"}, int'(locked), int'(m_locked));
  endtask

  task automatic step_and_compare(input string tag);
    model_step();
    next_decision();
    compare_model(tag);
  endtask

  function automatic int dut_code();
    return int'({coarse_sel, fine_sel});
  endfunction

  task automatic do_reset(input int tgt);
    @(negedge clk);
    rst_n = 1'b0;
    target_count  = 16'(tgt);
    search_thresh = 16'd8;
    lock_thresh   = 16'd1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    spent = 0;
    first_win = 1;
    m_code = 128;
    m_step = 64;
    m_relearn = 0;
    m_locked = 0;
  endtask

  task automatic t_reset_state();
    do_reset(420);
    check_eq("R1 reset coarse_sel", int'(coarse_sel), 4);
    check_eq("R1 reset fine_sel", int'(fine_sel), 0);
    check_eq("R1 reset locked", int'(locked), 0);
    tick(40);
    check_eq("R2 no change mid first window", dut_code(), 128);
  endtask

  task automatic t_coarse_to_lock();
    // target code 200 -> count 420; expected 192,224,208,200 then lock
    step_and_compare("R4 coarse 1");
    check_eq("R3 R4 first coarse up by 64", dut_code(), 192);
    step_and_compare("R4 coarse 2");
    check_eq("R4 coarse halves to 32", dut_code(), 224);
    step_and_compare("R4 coarse 3");
    check_eq("R3 R4 down by 16", dut_code(), 208);
    step_and_compare("R4 coarse 4");
    check_eq("R4 down by 8", dut_code(), 200);
    step_and_compare("R6 lock");
    check_eq("R6 locked set", int'(locked), 1);
    check_eq("R6 code held", dut_code(), 200);
  endtask

  task automatic t_fine_keeps_lock();
    target_count = 16'd426;  // code 203
    for (int i = 0; i < 3; i++) begin
      step_and_compare("R5 fine");
      check_eq("R5 single step", dut_code(), 201 + i);
      check_eq("R7 lock kept in fine", int'(locked), 1);
    end
    step_and_compare("R6 relock at 203");
    check_eq("R6 lock at 203", dut_code(), 203);
  endtask

  task automatic t_drift_restart();
    target_count = 16'd220;  // code 100
    step_and_compare("R8 restart");
    check_eq("R8 restart step 64", dut_code(), 139);
    check_eq("R7 lock dropped by coarse", int'(locked), 0);
    for (int i = 0; i < 6; i++) step_and_compare("R8 search");
    check_eq("R8 final code", dut_code(), 100);
    check_eq("R6 relocked", int'(locked), 1);
  endtask

  task automatic t_glitch_ignored();
    tick(20);
    target_count = 16'd0;
    tick(10);
    check_eq("R2 mid-window glitch no move", dut_code(), 100);
    check_eq("R2 mid-window glitch lock kept", int'(locked), 1);
    target_count = 16'd220;
    step_and_compare("R2 after glitch");
    check_eq("R2 glitch ignored at decision", dut_code(), 100);
  endtask

  task automatic t_sat_high();
    int exp_seq [8] = '{192, 224, 240, 248, 252, 254, 255, 255};
    do_reset(700);
    foreach (exp_seq[i]) begin
      step_and_compare("R9 high");
      check_eq("R9 saturate high", dut_code(), exp_seq[i]);
    end
  endtask

  task automatic t_sat_low();
    int exp_seq [9] = '{64, 32, 16, 8, 4, 2, 1, 0, 0};
    do_reset(0);
    foreach (exp_seq[i]) begin
      step_and_compare("R9 low");
      check_eq("R9 R3 saturate low", dut_code(), exp_seq[i]);
    end
  endtask

  initial begin
    checks = 0;
    failures = 0;
    done = 0;
    rst_n = 1'b0;
    target_count = '0;
    search_thresh = 16'd8;
    lock_thresh = 16'd1;
    t_reset_state();
    t_coarse_to_lock();
    t_fine_keeps_lock();
    t_drift_restart();
    t_glitch_ignored();
    t_sat_high();
    t_sat_low();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule